// File: doc/BRIEF.md
# Two-Wire Controller Command Decoder

This block accepts write-only command words for a two-wire serial (I2C/SMBus) controller and turns them into three kinds of output for the bus engine. The first is a set of persistent mode flags: host role, client role, high-speed, SMBus, packet error checking, alternate command handling and FIFO use. The second is an error lock. The third is a set of single-cycle action strobes. Every command bit acts only when it is written as 1. Bits written as 0 leave the state unchanged, so software can set or clear one feature without a read-modify-write.

Each enable has a matching disable bit, and the disable bit wins when both are written 1. A change of role between host and client is accepted only while the engine reports that the current transfer is complete. A NACK, a host-code acknowledge error or an SMBus timeout sets the lock. While the lock is set, new bus activity is held off until software writes the lock-release bit. A software reset bit returns every flag to its power-up value.

Top module: `twc_cmd_reg`

## Requirements
- R1: While reset is asserted and after it is released, all mode flags, the lock and all strobes are 0.
- R2: Feature enable/disable pairs sit at these positions: high-speed 8/9, SMBus 10/11, PEC 12/13, alternate command 16/17, FIFO 28/29. Writing enable=1 sets the flag and writing disable=1 clears it. When both are written 1, the flag is cleared. When both are written 0, the flag keeps its value.
- R3: Host enable is bit 2 and host disable is bit 3; client enable is bit 4 and client disable is bit 5. An enable acts only if its own disable bit is 0 in the same word. If both roles are requested in one word, neither enable acts. Enabling one role clears the other, so host and client are never both 1.
- R4: A request that moves from client to host, or from host to client, is ignored unless the transfer-complete input is 1 in the write cycle. Entering a role from the idle state (neither role set) is not gated.
- R5: A pulse on any of the NACK, code-acknowledge-error or timeout inputs sets the lock. The lock stays set until bit 26 (lock release) is written. If an error and a release arrive in the same cycle, the lock ends up set.
- R6: START (bit 0), STOP (bit 1) and PEC request (bit 14) each produce a one-cycle strobe in the cycle after the write. Each is suppressed while the lock is set.
- R7: QUICK (bit 6) and bus CLEAR (bit 15) strobe only when host mode is enabled and the lock is clear.
- R8: The holding-clear bit (bit 24) produces the hold_clr_o strobe, which tells the engine to empty the transmit holding register and to set its transmit-ready and transfer-complete flags. This strobe fires even while the lock is set.
- R9: A NACK pulse received while host mode is enabled forces a stop strobe in the next cycle, with no command written.
- R10: Software reset (bit 7) clears every mode flag and the lock, overrides all other bits and error inputs in that cycle, and emits no strobe.
- R11: In a cycle with no write and no NACK, every strobe is 0 in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_wr_i | input | 1 | Command word write enable |
| cmd_data_i | input | 32 | Command word |
| xfer_done_i | input | 1 | Transfer-complete flag from the bus engine |
| nack_i | input | 1 | NACK received event |
| code_ack_err_i | input | 1 | Host-code acknowledge error event |
| smb_timeout_i | input | 1 | SMBus timeout event |
| host_en_o | output | 1 | Host role enabled |
| client_en_o | output | 1 | Client role enabled |
| hs_en_o | output | 1 | High-speed mode enabled |
| smb_en_o | output | 1 | SMBus mode enabled |
| pec_en_o | output | 1 | Packet error checking enabled |
| alt_cmd_en_o | output | 1 | Alternate command mode enabled |
| fifo_en_o | output | 1 | FIFOs enabled |
| lock_o | output | 1 | Error lock |
| start_o | output | 1 | START strobe |
| stop_o | output | 1 | STOP strobe (commanded or forced by a NACK) |
| quick_o | output | 1 | Quick command strobe |
| bus_clear_o | output | 1 | Bus clear strobe |
| pec_req_o | output | 1 | PEC request strobe |
| hold_clr_o | output | 1 | Holding-register clear strobe, also sets transmit-ready and transfer-complete |

## Verification
The assertions take the error inputs and the transfer-complete flag to be ordinary synchronous levels. They also allow errors, command writes and software reset to coincide in any combination. The stimulus changes every input only at the falling clock edge. It covers every enable/disable combination from each starting state, and every role request from each role with transfer-complete both high and low. It also covers all 64 subsets of the strobe bits under each lock and host combination, followed by a long pseudo-random phase in which software reset and error pulses are kept rare, so that the state can build up between them.

// File: rtl/twc_cmd_pkg.sv
package twc_cmd_pkg;
  localparam int CMD_W     = 32;
  localparam int NUM_PAIRS = 5;
  localparam int RST_STAGES = 2;

  localparam int B_START   = 0;
  localparam int B_STOP    = 1;
  localparam int B_MSEN    = 2;
  localparam int B_MSDIS   = 3;
  localparam int B_SVEN    = 4;
  localparam int B_SVDIS   = 5;
  localparam int B_QUICK   = 6;
  localparam int B_SWRST   = 7;
  localparam int B_CLEAR   = 15;
  localparam int B_PECRQ   = 14;
  localparam int B_HOLDCLR = 24;
  localparam int B_LOCKCLR = 26;

  // pair index: 0 high-speed, 1 SMBus, 2 PEC, 3 alternate command, 4 FIFO
  function automatic int pair_en_bit(input int idx);
    case (idx)
      0:       return 8;
      1:       return 10;
      2:       return 12;
      3:       return 16;
      default: return 28;
    endcase
  endfunction

  function automatic int pair_dis_bit(input int idx);
    return pair_en_bit(idx) + 1;
  endfunction

  function automatic logic [CMD_W-1:0] used_mask();
    logic [CMD_W-1:0] m;
    m = '0;
    for (int i = 0; i <= B_SWRST; i++) m[i] = 1'b1;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      m[pair_en_bit(p)]  = 1'b1;
      m[pair_dis_bit(p)] = 1'b1;
    end
    m[B_CLEAR] = 1'b1;
    m[B_PECRQ] = 1'b1;
    m[B_HOLDCLR] = 1'b1;
    m[B_LOCKCLR] = 1'b1;
    return m;
  endfunction

  typedef struct packed {
    logic start;
    logic stop;
    logic quick;
    logic bus_clear;
    logic pec_req;
    logic hold_clr;
  } twc_strobe_t;
endpackage

// File: rtl/twc_rst_sync.sv
module twc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/twc_en_pair.sv
module twc_en_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_ce;

  always_comb begin
    flag_ce = soft_rst_i | set_i | clr_i;
    flag_d  = flag_q;
    if (soft_rst_i || clr_i) flag_d = 1'b0;
    else if (set_i)          flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_PAIR_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !flag_o); // R2
  AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !set_i && !clr_i && !soft_rst_i |=> $stable(flag_o)); // R2
endmodule

// File: rtl/twc_role_ctl.sv
module twc_role_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst_i,
  input  logic host_en_i,
  input  logic host_dis_i,
  input  logic client_en_i,
  input  logic client_dis_i,
  input  logic xfer_done_i,
  output logic host_o,
  output logic client_o
);
  logic host_q, client_q, host_d, client_d;
  logic host_req, client_req, host_go, client_go;

  always_comb begin
    host_req   = host_en_i & ~host_dis_i;
    client_req = client_en_i & ~client_dis_i;
    host_go    = host_req & ~client_req & (~client_q | xfer_done_i);
    client_go  = client_req & ~host_req & (~host_q | xfer_done_i);

    host_d = host_q;
    if (soft_rst_i)                     host_d = 1'b0;
    else if (host_go)                   host_d = 1'b1;
    else if (host_dis_i || client_go)   host_d = 1'b0;

    client_d = client_q;
    if (soft_rst_i)                     client_d = 1'b0;
    else if (client_go)                 client_d = 1'b1;
    else if (client_dis_i || host_go)   client_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q   <= 1'b0;
      client_q <= 1'b0;
    end else begin
      host_q   <= host_d;
      client_q <= client_d;
    end
  end

  assign host_o   = host_q;
  assign client_o = client_q;

  AST_ROLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_q && client_q)); // R3
  AST_HOST_SWITCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    client_q && !xfer_done_i |=> !host_q); // R4
  AST_CLIENT_SWITCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    host_q && !xfer_done_i && !client_dis_i && !soft_rst_i |=> !client_q || $past(client_q)); // R4
endmodule

// File: rtl/twc_lock_strobe.sv
module twc_lock_strobe
  import twc_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst_i,
  input  logic        host_i,
  input  logic        err_i,
  input  logic        nack_i,
  input  logic        lock_clr_i,
  input  twc_strobe_t req_i,
  output logic        lock_o,
  output twc_strobe_t strobe_o
);
  logic        lock_q, lock_d;
  twc_strobe_t strobe_q, strobe_d;

  always_comb begin
    lock_d = lock_q;
    if (soft_rst_i)      lock_d = 1'b0;
    else if (err_i)      lock_d = 1'b1;
    else if (lock_clr_i) lock_d = 1'b0;

    strobe_d = '0;
    if (!soft_rst_i) begin
      strobe_d.start     = req_i.start & ~lock_q;
      strobe_d.stop      = (req_i.stop & ~lock_q) | (nack_i & host_i);
      strobe_d.quick     = req_i.quick & ~lock_q & host_i;
      strobe_d.bus_clear = req_i.bus_clear & ~lock_q & host_i;
      strobe_d.pec_req   = req_i.pec_req & ~lock_q;
      strobe_d.hold_clr  = req_i.hold_clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      strobe_q <= '0;
    end else begin
      lock_q   <= lock_d;
      strobe_q <= strobe_d;
    end
  end

  assign lock_o   = lock_q;
  assign strobe_o = strobe_q;

  AST_ERR_SETS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    err_i && !soft_rst_i |=> lock_q); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && !lock_clr_i && !soft_rst_i |=> lock_q); // R5
  AST_LOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> !strobe_q.start && !strobe_q.quick && !strobe_q.bus_clear && !strobe_q.pec_req); // R6
  AST_HOST_ONLY_CMDS: assert property (@(posedge clk) disable iff (!rst_n)
    !host_i |=> !strobe_q.quick && !strobe_q.bus_clear); // R7
  AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    nack_i && host_i && !soft_rst_i |=> strobe_q.stop); // R9
endmodule

// File: rtl/twc_cmd_reg.sv
module twc_cmd_reg
  import twc_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_data_i,
  input  logic             xfer_done_i,
  input  logic             nack_i,
  input  logic             code_ack_err_i,
  input  logic             smb_timeout_i,
  output logic             host_en_o,
  output logic             client_en_o,
  output logic             hs_en_o,
  output logic             smb_en_o,
  output logic             pec_en_o,
  output logic             alt_cmd_en_o,
  output logic             fifo_en_o,
  output logic             lock_o,
  output logic             start_o,
  output logic             stop_o,
  output logic             quick_o,
  output logic             bus_clear_o,
  output logic             pec_req_o,
  output logic             hold_clr_o
);
  localparam logic [CMD_W-1:0] USED = used_mask();

  logic             rst_n_s;
  logic [CMD_W-1:0] cmd_bits;
  logic             soft_rst;
  logic             cmd_unused;
  logic [NUM_PAIRS-1:0] pair_q;
  twc_strobe_t      req, strobe;

  twc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_n_s)
  );

  assign cmd_bits   = cmd_wr_i ? cmd_data_i : '0;
  assign soft_rst   = cmd_bits[B_SWRST];
  assign cmd_unused = ^(cmd_data_i & ~USED);

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    twc_en_pair u_pair (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .soft_rst_i (soft_rst),
      .set_i      (cmd_bits[pair_en_bit(g)]),
      .clr_i      (cmd_bits[pair_dis_bit(g)]),
      .flag_o     (pair_q[g])
    );
  end

  twc_role_ctl u_role (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .soft_rst_i   (soft_rst),
    .host_en_i    (cmd_bits[B_MSEN]),
    .host_dis_i   (cmd_bits[B_MSDIS]),
    .client_en_i  (cmd_bits[B_SVEN]),
    .client_dis_i (cmd_bits[B_SVDIS]),
    .xfer_done_i  (xfer_done_i),
    .host_o       (host_en_o),
    .client_o     (client_en_o)
  );

  always_comb begin
    req.start     = cmd_bits[B_START];
    req.stop      = cmd_bits[B_STOP];
    req.quick     = cmd_bits[B_QUICK];
    req.bus_clear = cmd_bits[B_CLEAR];
    req.pec_req   = cmd_bits[B_PECRQ];
    req.hold_clr  = cmd_bits[B_HOLDCLR];
  end

  twc_lock_strobe u_lock (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .soft_rst_i (soft_rst),
    .host_i     (host_en_o),
    .err_i      (nack_i | code_ack_err_i | smb_timeout_i),
    .nack_i     (nack_i),
    .lock_clr_i (cmd_bits[B_LOCKCLR]),
    .req_i      (req),
    .lock_o     (lock_o),
    .strobe_o   (strobe)
  );

  assign hs_en_o      = pair_q[0];
  assign smb_en_o     = pair_q[1];
  assign pec_en_o     = pair_q[2];
  assign alt_cmd_en_o = pair_q[3];
  assign fifo_en_o    = pair_q[4];
  assign start_o      = strobe.start;
  assign stop_o       = strobe.stop;
  assign quick_o      = strobe.quick;
  assign bus_clear_o  = strobe.bus_clear;
  assign pec_req_o    = strobe.pec_req;
  assign hold_clr_o   = strobe.hold_clr;

  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_wr_i && cmd_data_i[B_SWRST] |=> !host_en_o && !client_en_o && !lock_o &&
      (pair_q == '0) && !start_o && !stop_o && !hold_clr_o); // R10
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cmd_wr_i && !nack_i |=> !start_o && !stop_o && !quick_o && !bus_clear_o &&
      !pec_req_o && !hold_clr_o); // R11
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_s |-> !host_en_o && !client_en_o && !lock_o && !start_o); // R1
endmodule

// File: tb/test_twc_cmd_reg.sv
`timescale 1ns/1ps
module test_twc_cmd_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_wr_i;
  logic [31:0] cmd_data_i;
  logic        xfer_done_i, nack_i, code_ack_err_i, smb_timeout_i;
  logic host_en_o, client_en_o, hs_en_o, smb_en_o, pec_en_o, alt_cmd_en_o, fifo_en_o, lock_o;
  logic start_o, stop_o, quick_o, bus_clear_o, pec_req_o, hold_clr_o;

  always #2 clk = ~clk;

  twc_cmd_reg i_twc_cmd_reg (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int pen[5]  = '{8, 10, 12, 16, 28};
  int pdis[5] = '{9, 11, 13, 17, 29};

  bit m_host, m_client, m_lock;
  bit [4:0] m_pair;
  bit e_start, e_stop, e_quick, e_clr, e_pec, e_hclr;

  task automatic chk(input string tag, input logic got, input bit exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [4:0] gp;
    gp = {fifo_en_o, alt_cmd_en_o, pec_en_o, smb_en_o, hs_en_o};
    for (int k = 0; k < 5; k++) chk($sformatf("R2 pair%0d", k), gp[k], m_pair[k]);
    chk("R3/R4 host", host_en_o, m_host);
    chk("R3/R4 client", client_en_o, m_client);
    chk("R5 lock", lock_o, m_lock);
    chk("R6 start", start_o, e_start);
    chk("R6/R9 stop", stop_o, e_stop);
    chk("R7 quick", quick_o, e_quick);
    chk("R7 clear", bus_clear_o, e_clr);
    chk("R6 pecreq", pec_req_o, e_pec);
    chk("R8 holdclr", hold_clr_o, e_hclr);
  endtask

  // one cycle: called at a falling edge, returns at the next falling edge after checking
  task automatic step(input bit wr, input bit [31:0] d, input bit done, input bit [2:0] err);
    bit sr, hg, cg, hreq, creq, any_err;
    cmd_wr_i = wr; cmd_data_i = d; xfer_done_i = done;
    nack_i = err[0]; code_ack_err_i = err[1]; smb_timeout_i = err[2];
    if (!wr) d = '0;
    sr = d[7];
    any_err = |err;
    e_start = !sr && d[0] && !m_lock;
    e_stop  = !sr && ((d[1] && !m_lock) || (err[0] && m_host));
    e_quick = !sr && d[6] && !m_lock && m_host;
    e_clr   = !sr && d[15] && !m_lock && m_host;
    e_pec   = !sr && d[14] && !m_lock;
    e_hclr  = !sr && d[24];
    hreq = d[2] && !d[3];
    creq = d[4] && !d[5];
    hg = hreq && !creq && (!m_client || done);
    cg = creq && !hreq && (!m_host || done);
    if (sr) begin
      m_host = 0; m_client = 0; m_lock = 0; m_pair = '0;
    end else begin
      if (hg) m_host = 1; else if (d[3] || cg) m_host = 0;
      if (cg) m_client = 1; else if (d[5] || hg) m_client = 0;
      if (any_err) m_lock = 1; else if (d[26]) m_lock = 0;
      for (int k = 0; k < 5; k++)
        if (d[pdis[k]]) m_pair[k] = 0; else if (d[pen[k]]) m_pair[k] = 1;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(1'b0, 32'hFFFF_FFFF, 1'b0, 3'b000); // R11: write data ignored without strobe
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit [31:0] lfsr;
    bit [31:0] w;
    rst_n = 0; cmd_wr_i = 0; cmd_data_i = '0; xfer_done_i = 0;
    nack_i = 0; code_ack_err_i = 0; smb_timeout_i = 0;
    m_host = 0; m_client = 0; m_lock = 0; m_pair = '0;
    e_start = 0; e_stop = 0; e_quick = 0; e_clr = 0; e_pec = 0; e_hclr = 0;
    repeat (3) @(negedge clk);
    compare_all(); // R1 during reset
    rst_n = 1;
    repeat (4) @(negedge clk);
    compare_all(); // R1 after release

    // R2 sweep: each pair, each start value, each bit combination
    for (int k = 0; k < 5; k++)
      for (int init = 0; init < 2; init++)
        for (int c = 0; c < 4; c++) begin
          w = '0; w[init ? pen[k] : pdis[k]] = 1'b1;
          step(1, w, 0, 0);
          w = '0; w[pen[k]] = c[0]; w[pdis[k]] = c[1];
          step(1, w, 0, 0);
          idle();
        end

    // R3/R4 sweep: all role bit combinations from idle, host and client, done low and high
    for (int init = 0; init < 3; init++)
      for (int dn = 0; dn < 2; dn++)
        for (int c = 0; c < 16; c++) begin
          step(1, 32'h28, 1, 0);
          if (init == 1) step(1, 32'h04, 1, 0);
          if (init == 2) step(1, 32'h10, 1, 0);
          step(1, 32'(c) << 2, dn[0], 0);
          idle();
        end

    // R6/R7/R8 sweep: every subset of strobe bits under each lock/host state
    for (int lk = 0; lk < 2; lk++)
      for (int h = 0; h < 2; h++)
        for (int s = 0; s < 64; s++) begin
          step(1, 32'h0400_0028, 1, 0);
          if (h) step(1, 32'h04, 1, 0);
          if (lk) step(0, 0, 0, 3'b100);
          w = '0;
          w[0] = s[0]; w[1] = s[1]; w[6] = s[2];
          w[14] = s[3]; w[15] = s[4]; w[24] = s[5];
          step(1, w, 0, 0);
          idle();
        end

    // R5: each error source, release, and release colliding with an error
    for (int e = 0; e < 3; e++) begin
      step(0, 0, 0, 3'(1 << e));
      idle();
      step(1, 32'h0400_0000, 0, 0);
      step(1, 32'h0400_0000, 0, 3'(1 << e));
      step(1, 32'h0400_0000, 0, 0);
    end

    // R9: NACK with and without host mode
    step(1, 32'h0000_0004, 1, 0);
    step(0, 0, 0, 3'b001);
    idle();
    step(1, 32'h0400_0008, 0, 0);
    step(0, 0, 0, 3'b001);
    step(1, 32'h0400_0000, 0, 0);

    // R10: build state up then software reset with everything else set
    step(1, 32'h1001_1504, 1, 0);
    step(0, 0, 0, 3'b010);
    step(1, 32'hFFFF_FFFF, 1, 3'b111);
    idle();

    // random phase
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 6000; i++) begin
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      w = lfsr;
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      if (lfsr[7:0] != 8'h00) w[7] = 1'b0;
      if (lfsr[11:8] != 4'h0) w[26] = 1'b0;
      step(lfsr[12] | lfsr[13], w, lfsr[14],
           {lfsr[20:18] == 3'b000, lfsr[23:21] == 3'b000, lfsr[27:24] == 4'h0});
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule